// File: doc/BRIEF.md
# Status-framing SPI slave serializer

This block reports the state of eight digital inputs, together with a status byte, to a host over a mode 0 SPI link (clock idles low, data sampled on the rising edge). When chip select falls, a snapshot is taken of the eight inputs, of two alarm flags and of the parity of four input groups. The snapshot is then shifted out MSB first. A mode input picks either a 16-bit frame (inputs plus status byte) or an 8-bit frame (inputs only).

Each bit on the serial data input is captured on an SCK rising edge and enters the bottom of the same shift register. Several devices can therefore be chained, and each one forwards the upstream stream after its own frame. When the power-good flag is low during a transfer, the data output is held low, so the host reads a stop bit of 0 and can tell a dead device from a live one. A complementary copy of the data output, and an enable for an external tri-state driver, are also provided.

All SPI pins and flags are oversampled by a faster system clock through a synchronizer. Edges of chip select and SCK are detected in that clock domain, so the block has a single clock.

Top module: `status_spi_serializer`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_miso` and `spi_miso_n` are all 0.
- R2: While `spi_csn` is high, `spi_miso_oe`, `spi_miso` and `spi_miso_n` are 0. SCK and MOSI activity in that time does not shift the register, so the next frame is unchanged.
- R3: In 16-bit mode (`len_sel`=0) the frame is sent MSB first. Bits 15..8 are `in_state[7:0]`, bit 7 is the inverse of `undervolt`, bit 6 is the inverse of `overtemp`, bit 1 is 0 and bit 0 is 1. The first bit is valid before the first SCK rising edge, and each following bit is valid after an SCK falling edge.
- R4: Bit 5 is the XNOR of all eight inputs. Bit 4 covers `in_state[7:4]`, bit 3 covers `in_state[3:0]` and bit 2 covers `in_state[5:2]`. Each of these bits is 1 when its group holds an even number of ones.
- R5: In 8-bit mode (`len_sel`=1) only `in_state[7:0]` is sent, MSB first. Bit 8 onward is the MOSI stream delayed by eight bits.
- R6: In 16-bit mode, bit 16 onward of a transfer is the MOSI stream delayed by sixteen bits (daisy chain).
- R7: `len_sel` is sampled when chip select falls. A change of `len_sel` during a transfer has no effect on that transfer.
- R8: The inputs and alarms are captured when chip select falls. A change of them during a transfer does not alter the frame being sent.
- R9: While `pwr_ok` is low and `spi_csn` is low, `spi_miso`=0, `spi_miso_n`=1 and `spi_miso_oe`=1. Shifting continues during the loss, so correct bits resume once `pwr_ok` returns.
- R10: Whenever `spi_miso_oe` is 1, `spi_miso_n` is the complement of `spi_miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data in |
| len_sel | input | 1 | 0: 16-bit frame, 1: 8-bit frame |
| in_state | input | 8 | Filtered input states, bit 7 sent first |
| undervolt | input | 1 | Supply undervoltage flag, active high |
| overtemp | input | 1 | Overtemperature flag, active high |
| pwr_ok | input | 1 | Power-good flag, active high |
| spi_miso | output | 1 | Serial data out |
| spi_miso_n | output | 1 | Complement of serial data out |
| spi_miso_oe | output | 1 | Enable for the external tri-state drivers |

## Verification
Power loss and shifting can fall in the same system-clock cycle. The bench drops `pwr_ok` on the same edge as an SCK falling edge in the middle of a 16-bit frame, and raises it again three bits later, also together with a falling edge. The forced bits must read 0 on the data output and 1 on its complement. The bits after recovery must equal the frame bits at their normal positions, which shows that the register kept shifting during the loss. A second pairing, a load against input or mode changes, is judged by changing `in_state` or `len_sel` during a transfer and expecting the frame as it stood when chip select fell.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int IN_W    = 8;
  localparam int FRAME_W = 16;

  typedef logic [IN_W-1:0]    in_vec_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic {
    LEN_WORD = 1'b0,
    LEN_BYTE = 1'b1
  } len_mode_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ssr_frame_build.sv
module ssr_frame_build
  import ssr_pkg::*;
(
  input  in_vec_t in_state,
  input  logic    undervolt,
  input  logic    overtemp,
  output frame_t  frame
);
  logic par_all, par_hi, par_lo, par_mid;

  // Even-parity flags: 1 when the group carries an even count of ones
  always_comb begin
    par_all = ~^in_state;
    par_hi  = ~^in_state[7:4];
    par_lo  = ~^in_state[3:0];
    par_mid = ~^in_state[5:2];
  end

  assign frame = {in_state, ~undervolt, ~overtemp,
                  par_all, par_hi, par_lo, par_mid, 1'b0, 1'b1};
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_s,
  input  logic      sck_s,
  input  logic      mosi_s,
  input  logic      len_s,
  input  frame_t    frame,
  output logic      tap,
  output logic      load_p,
  output len_mode_e mode_q,
  output frame_t    sr_q
);
  logic cs_d, sck_d, cap_q;
  logic sck_rise, sck_fall;

  assign load_p   = cs_d & ~cs_s;
  assign sck_rise = ~cs_s & sck_s & ~sck_d;
  assign sck_fall = ~cs_s & ~sck_s & sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
      cap_q  <= 1'b0;
      sr_q   <= '0;
      mode_q <= LEN_WORD;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
      if (load_p) begin
        mode_q <= len_mode_e'(len_s);
        if (len_mode_e'(len_s) == LEN_BYTE)
          sr_q <= {{(FRAME_W-IN_W){1'b0}}, frame[FRAME_W-1 -: IN_W]};
        else
          sr_q <= frame;
      end else begin
        if (sck_rise) cap_q <= mosi_s;
        if (sck_fall) sr_q  <= {sr_q[FRAME_W-2:0], cap_q};
      end
    end
  end

  // Byte mode taps the register at the byte boundary, so MOSI re-emerges after 8 bits
  assign tap = (mode_q == LEN_BYTE) ? sr_q[IN_W-1] : sr_q[FRAME_W-1];
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic pg_s,
  input  logic tap,
  output logic miso,
  output logic miso_n,
  output logic miso_oe
);
  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      miso_oe <= 1'b0;
      miso    <= 1'b0;
      miso_n  <= 1'b0;
    end else if (!pg_s) begin
      miso_oe <= 1'b1;
      miso    <= 1'b0;
      miso_n  <= 1'b1;
    end else begin
      miso_oe <= 1'b1;
      miso    <= tap;
      miso_n  <= ~tap;
    end
  end
endmodule

// File: rtl/status_spi_serializer.sv
module status_spi_serializer
  import ssr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_csn,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          len_sel,
  input  logic [IN_W-1:0] in_state,
  input  logic          undervolt,
  input  logic          overtemp,
  input  logic          pwr_ok,
  output logic          spi_miso,
  output logic          spi_miso_n,
  output logic          spi_miso_oe
);
  localparam int SYNC_W = IN_W + 7;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

  logic [SYNC_W-1:0] raw_v, sync_v;
  logic      cs_s, sck_s, mosi_s, len_s, pg_s, uv_s, ot_s;
  in_vec_t   in_s;
  frame_t    frame, sr_q;
  logic      tap, load_p;
  len_mode_e mode_q;

  assign raw_v = {spi_csn, spi_sck, spi_mosi, len_sel, pwr_ok, undervolt, overtemp, in_state};

  ssr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(sync_v)
  );

  assign {cs_s, sck_s, mosi_s, len_s, pg_s, uv_s, ot_s, in_s} = sync_v;

  ssr_frame_build u_frame (
    .in_state(in_s), .undervolt(uv_s), .overtemp(ot_s), .frame(frame)
  );

  ssr_shifter u_shift (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .len_s(len_s), .frame(frame), .tap(tap), .load_p(load_p),
    .mode_q(mode_q), .sr_q(sr_q)
  );

  ssr_out_stage u_out (
    .clk(clk), .rst(rst), .cs_s(cs_s), .pg_s(pg_s), .tap(tap),
    .miso(spi_miso), .miso_n(spi_miso_n), .miso_oe(spi_miso_oe)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      cs_s,
  input logic      pg_s,
  input logic      load_p,
  input len_mode_e mode_q,
  input frame_t    sr_q,
  input logic      miso,
  input logic      miso_n,
  input logic      miso_oe
);
  a_r2_idle_undriven: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> (!miso_oe && !miso && !miso_n));

  a_r10_complement: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (miso_n == !miso));

  a_r9_power_forced: assert property (@(posedge clk) disable iff (rst)
    (!$past(pg_s) && !$past(cs_s)) |-> (miso_oe && !miso && miso_n));

  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && !$past(cs_s) && !$past(cs_s, 2)) |-> $stable(mode_q));

  a_r4_parity_loaded: assert property (@(posedge clk) disable iff (rst)
    ($past(load_p) && mode_q == LEN_WORD) |->
      (sr_q[5] == ~^sr_q[15:8] && sr_q[2] == ~^sr_q[13:10]));

  a_r3_stop_bits: assert property (@(posedge clk) disable iff (rst)
    ($past(load_p) && mode_q == LEN_WORD) |-> (sr_q[1:0] == 2'b01));
endmodule

bind status_spi_serializer ssr_checker u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .pg_s(pg_s), .load_p(load_p),
  .mode_q(mode_q), .sr_q(sr_q), .miso(spi_miso), .miso_n(spi_miso_n),
  .miso_oe(spi_miso_oe)
);

// File: tb/status_spi_serializer_test.sv
module status_spi_serializer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, spi_csn, spi_sck, spi_mosi, len_sel, undervolt, overtemp, pwr_ok;
  logic [7:0] in_state;
  logic spi_miso, spi_miso_n, spi_miso_oe;

  status_spi_serializer uut (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .len_sel(len_sel), .in_state(in_state), .undervolt(undervolt), .overtemp(overtemp),
    .pwr_ok(pwr_ok), .spi_miso(spi_miso), .spi_miso_n(spi_miso_n),
    .spi_miso_oe(spi_miso_oe)
  );

  localparam int HALF = 8;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int chg_at = -1;  logic [7:0] chg_in;  logic chg_len;  bit chg_is_len;
  int pg_drop_at = -1, pg_back_at = -1;

  function automatic logic [15:0] exp_frame(logic [7:0] d, logic uv, logic ot);
    return {d, ~uv, ~ot, ~^d, ~^d[7:4], ~^d[3:0], ~^d[5:2], 1'b0, 1'b1};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(int nbits, logic [31:0] mosi_v,
                      output logic [31:0] got, output logic [31:0] got_n, output logic oe_all);
    got = '0; got_n = '0; oe_all = 1'b1;
    spi_csn = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      spi_mosi = mosi_v[nbits-1-k];
      if (k == chg_at) begin
        if (chg_is_len) len_sel = chg_len; else in_state = chg_in;
      end
      tick(HALF);
      got[nbits-1-k]   = spi_miso;
      got_n[nbits-1-k] = spi_miso_n;
      oe_all           = oe_all & spi_miso_oe;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
      if (k == pg_drop_at) pwr_ok = 1'b0;
      if (k == pg_back_at) pwr_ok = 1'b1;
    end
    tick(HALF);
    spi_csn = 1'b1;
    tick(HALF);
    chg_at = -1; pg_drop_at = -1; pg_back_at = -1;
  endtask

  task automatic t_reset();
    check("R1", {29'b0, spi_miso_oe, spi_miso, spi_miso_n}, 32'h0, "outputs after reset");
  endtask

  task automatic t_idle();
    logic [31:0] g, gn; logic oe; bit bad = 0;
    in_state = 8'h5A; undervolt = 0; overtemp = 0; len_sel = 0; tick(6);
    for (int i = 0; i < 20; i++) begin
      spi_mosi = i[0]; spi_sck = 1'b1; tick(HALF);
      if (spi_miso_oe || spi_miso || spi_miso_n) bad = 1;
      spi_sck = 1'b0; tick(HALF);
    end
    check("R2", {31'b0, bad}, 32'h0, "outputs driven while deselected");
    xfer(16, 32'h0, g, gn, oe);
    check("R2", g, {16'h0, exp_frame(8'h5A, 0, 0)}, "frame after ignored clocks");
  endtask

  task automatic t_frame16(logic [7:0] d, logic uv, logic ot);
    logic [31:0] g, gn; logic oe;
    in_state = d; undervolt = uv; overtemp = ot; len_sel = 0; tick(6);
    xfer(16, 32'h0, g, gn, oe);
    check("R3 R4", g, {16'h0, exp_frame(d, uv, ot)}, "16-bit frame");
    check("R10", gn, {16'h0, ~exp_frame(d, uv, ot)}, "inverted output");
    check("R3", {31'b0, oe}, 32'h1, "enable during transfer");
  endtask

  task automatic t_byte();
    logic [31:0] g, gn; logic oe;
    in_state = 8'hC6; len_sel = 1; tick(6);
    xfer(16, 32'h0000_9B00, g, gn, oe);
    check("R5", g, 32'h0000_C69B, "8-bit frame then MOSI");
    len_sel = 0; tick(4);
  endtask

  task automatic t_daisy();
    logic [31:0] g, gn; logic oe;
    in_state = 8'h3C; undervolt = 1; overtemp = 0; len_sel = 0; tick(6);
    xfer(32, 32'hB7E1_0000, g, gn, oe);
    check("R6", g, {exp_frame(8'h3C, 1, 0), 16'hB7E1}, "daisy chain 16-bit");
  endtask

  task automatic t_mode_change();
    logic [31:0] g, gn; logic oe;
    in_state = 8'h96; undervolt = 0; overtemp = 1; len_sel = 0; tick(6);
    chg_at = 3; chg_is_len = 1; chg_len = 1;
    xfer(16, 32'h0, g, gn, oe);
    check("R7", g, {16'h0, exp_frame(8'h96, 0, 1)}, "word mode kept");
    tick(6);
    chg_at = 2; chg_is_len = 1; chg_len = 0;
    xfer(16, 32'h0000_E400, g, gn, oe);
    check("R7", g, 32'h0000_96E4, "byte mode kept");
    len_sel = 0; tick(4);
  endtask

  task automatic t_snapshot();
    logic [31:0] g, gn; logic oe;
    in_state = 8'h71; undervolt = 0; overtemp = 0; tick(6);
    chg_at = 2; chg_is_len = 0; chg_in = 8'h0E;
    xfer(16, 32'h0, g, gn, oe);
    check("R8", g, {16'h0, exp_frame(8'h71, 0, 0)}, "snapshot held");
    tick(6);
    xfer(16, 32'h0, g, gn, oe);
    check("R8", g, {16'h0, exp_frame(8'h0E, 0, 0)}, "next snapshot");
  endtask

  task automatic t_power();
    logic [31:0] g, gn; logic oe; logic [15:0] f, m;
    in_state = 8'hE7; undervolt = 0; overtemp = 0; pwr_ok = 0; tick(6);
    xfer(16, 32'h0, g, gn, oe);
    check("R9", g, 32'h0, "data during power loss");
    check("R9", gn, 32'h0000_FFFF, "inverted data during power loss");
    check("R9", {31'b0, oe}, 32'h1, "enable during power loss");
    pwr_ok = 1; tick(6);
    f = exp_frame(8'hE7, 0, 0);
    m = 16'h0E00;
    pg_drop_at = 3; pg_back_at = 6;
    xfer(16, 32'h0, g, gn, oe);
    check("R9", g, {16'h0, f & ~m}, "loss on shift edge, data");
    check("R9", gn, {16'h0, ~f | m}, "loss on shift edge, inverted");
    pwr_ok = 1;
  endtask

  initial begin
    rst = 1; spi_csn = 1; spi_sck = 0; spi_mosi = 0; len_sel = 0;
    in_state = 0; undervolt = 0; overtemp = 0; pwr_ok = 1;
    tick(5);
    rst = 0;
    tick(1);
    t_reset();
    t_idle();
    t_frame16(8'hA5, 0, 0);
    t_frame16(8'h00, 1, 1);
    t_frame16(8'hFF, 1, 0);
    t_frame16(8'h34, 0, 1);
    t_byte();
    t_daisy();
    t_mode_change();
    t_snapshot();
    t_power();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule